// File: doc/BRIEF.md
# Serial bit-change detector with registered and combinational flags

The block watches a one-bit serial input that is sampled on every rising clock edge and reports when the newly presented bit differs from the bit sampled before it. In other words, it detects either of the two-bit patterns 01 and 10. Two flags are produced side by side from the same input.

The first flag comes from a five-state machine whose output depends on the state alone. It is therefore glitch-free, and it rises one clock after the change is sampled. The second flag comes from a three-state machine whose output is decoded from the state and the live input. It rises in the same cycle in which the differing bit is presented.

A synchronous reset clears the history in both machines. Neither flag can fire on the first bit after reset, because no earlier bit exists to compare it with. If the five-state register ever holds an encoding that is not assigned to a state, it goes back to the no-history state on the next edge.

Top module: `bitchange_detect`

## Requirements
- R1: While `rst` is high at a rising edge, both machines enter the no-history state. `mealy_hit` is 0 for as long as `rst` is high, and `moore_hit` is 0 in the cycle that follows a reset edge.
- R2: The first bit sampled after reset raises neither flag, whatever value the bit before the reset had. This means `mealy_hit` is 0 while that bit is presented and `moore_hit` is 0 in the cycle after it.
- R3: `mealy_hit` is 1 in the same cycle in which `din` differs from the most recently sampled bit, provided a bit has been sampled since reset.
- R4: `mealy_hit` is 0 while `din` equals the most recently sampled bit.
- R5: Outside reset, `moore_hit` in each cycle equals the value `mealy_hit` had just before the preceding rising edge. This makes the registered flag exactly one clock later than the combinational flag.
- R6: For an alternating input, `moore_hit` stays high on every cycle after the second sampled bit, with no gap between consecutive changes.
- R7: `moore_hit` depends only on registered state. Changing `din` between clock edges leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial bit, sampled every rising edge |
| moore_hit | output | 1 | Registered change flag, one cycle after the change |
| mealy_hit | output | 1 | Combinational change flag, in the cycle of the change |

## Verification
The hardest situation to reach is a first bit after reset that differs from the last bit before reset. This is the only case where stale history would show up as a false flag. The bench sweeps every input sequence of one to eight bits, and each sequence opens with a reset. Every possible last bit of one sequence is therefore followed, through a reset, by every possible first bit of the next. Within each cycle the bench also flips `din` briefly between edges, so that a state-only output is distinguished from a decoded one.

// File: rtl/bitchange_pkg.sv
package bitchange_pkg;
  localparam int MOORE_W = 3;
  localparam int MEALY_W = 2;

  typedef enum logic [MOORE_W-1:0] {
    MO_IDLE  = 3'd0,
    MO_LAST0 = 3'd1,
    MO_LAST1 = 3'd2,
    MO_ROSE  = 3'd3,
    MO_FELL  = 3'd4
  } moore_st_t;

  typedef enum logic [MEALY_W-1:0] {
    ME_IDLE  = 2'd0,
    ME_LAST0 = 2'd1,
    ME_LAST1 = 2'd2
  } mealy_st_t;
endpackage

// File: rtl/bitchange_moore.sv
module bitchange_moore
  import bitchange_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit_o
);
  moore_st_t state_q, state_d;

  always_comb begin
    case (state_q)
      MO_IDLE:  state_d = din ? MO_LAST1 : MO_LAST0;
      MO_LAST0: state_d = din ? MO_ROSE  : MO_LAST0;
      MO_LAST1: state_d = din ? MO_LAST1 : MO_FELL;
      MO_ROSE:  state_d = din ? MO_LAST1 : MO_FELL;
      MO_FELL:  state_d = din ? MO_ROSE  : MO_LAST0;
      default:  state_d = MO_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= MO_IDLE;
    else     state_q <= state_d;
  end

  assign hit_o = (state_q == MO_ROSE) || (state_q == MO_FELL);

  // R1
  moore_reset_chk: assert property (@(posedge clk)
    rst |=> (state_q == MO_IDLE && !hit_o));

  // R2
  moore_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == MO_IDLE) |=> !hit_o);

  // R6
  moore_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == MO_ROSE && !din) |=> hit_o);
endmodule

// File: rtl/bitchange_mealy.sv
module bitchange_mealy
  import bitchange_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit_o
);
  mealy_st_t state_q, state_d;

  always_comb begin
    case (state_q)
      ME_IDLE, ME_LAST0, ME_LAST1: state_d = din ? ME_LAST1 : ME_LAST0;
      default:                     state_d = ME_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ME_IDLE;
    else     state_q <= state_d;
  end

  assign hit_o = !rst && (((state_q == ME_LAST0) && din) ||
                          ((state_q == ME_LAST1) && !din));

  // R1
  mealy_reset_quiet_chk: assert property (@(posedge clk)
    rst |-> !hit_o);

  // R2
  mealy_no_history_chk: assert property (@(posedge clk)
    (state_q == ME_IDLE) |-> !hit_o);

  // R4
  mealy_same_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ME_IDLE) |=> (din == $past(din)) |-> !hit_o);
endmodule

// File: rtl/bitchange_detect.sv
module bitchange_detect (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic moore_hit,
  output logic mealy_hit
);
  bitchange_moore u_moore (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .hit_o (moore_hit)
  );

  bitchange_mealy u_mealy (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .hit_o (mealy_hit)
  );

  // R5
  lag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    mealy_hit |=> moore_hit);

  // R5
  lag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mealy_hit |=> !moore_hit);
endmodule

// File: tb/test_bitchange_detect.sv
`timescale 1ns/1ps
module test_bitchange_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic moore_hit, mealy_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit have_prev = 0;
  bit prev_bit  = 0;
  bit exp_moore = 0;
  string moore_tag = "R1";

  always #2.5 clk = ~clk;

  bitchange_detect i_bitchange_detect (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .moore_hit (moore_hit),
    .mealy_hit (mealy_hit)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit b, bit r);
    bit    exp_mealy;
    string mtag;
    @(negedge clk);
    din = b;
    rst = r;
    #1;
    exp_mealy = !r && have_prev && (b != prev_bit);
    if (r)              mtag = "R1";
    else if (!have_prev) mtag = "R2";
    else if (exp_mealy) mtag = "R3";
    else                mtag = "R4";
    check(mtag, "mealy_hit", mealy_hit, exp_mealy);
    check(moore_tag, "moore_hit", moore_hit, exp_moore);
    din = ~b;
    #0.5;
    check("R7", "moore_hit under din toggle", moore_hit, exp_moore);
    din = b;
    @(posedge clk);
    if (r) begin
      have_prev = 0;
      exp_moore = 0;
      moore_tag = "R1";
    end else begin
      moore_tag = !have_prev ? "R2" : (exp_mealy && exp_moore) ? "R6" : "R5";
      exp_moore = exp_mealy;
      have_prev = 1;
      prev_bit  = b;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    for (int len = 1; len <= 8; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        step(1'b0, 1'b1);
        for (int i = 0; i < len; i++) step(pat[i], 1'b0);
      end
    end
    // R6: long alternating run
    step(1'b0, 1'b1);
    for (int i = 0; i < 16; i++) step(i[0], 1'b0);
    step(1'b0, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule